// File: doc/BRIEF.md
# Four-Line Serial Multiplexer Scan and Control Logic

This block is the control side of a four-line serial multiplexer as software sees it through a small register bus. It holds the control/status word, the per-line transmit enables and a line-configuration word. A rotating scanner picks one transmit-enabled line at a time and reports it as ready. The scanner also decides when received data is flagged as waiting. A single interrupt line is raised on either event and is cleared by the accesses that service it.

A scan runs on a one-cycle `scan_tick` strobe. It also runs in the cycle after every register access. The receive queue and the serial shifters live outside this block. The block only sees whether the queue holds a character, presents that character on a buffer read and pops it. A write of transmit data emits a one-cycle strobe that carries the byte and the number of the line currently reported ready.

Top module: `muxsio_ctl`

## Requirements
- R1: A scan runs only in a cycle with `scan_tick` high or in the cycle after a register access, and never in a cycle that carries an access itself. The transmit search within a scan runs only while scan-enable (status bit 0) is set and transmit-ready (status bit 13) is clear.
- R2: The search advances the scan pointer before it tests a line. It visits at most four lines, starting at the one after the last reported line (line 1 after reset), and stops at the first line whose enable bit is set in the transmit-control register (bit n for line n). If no line is enabled, nothing is reported.
- R3: When the search finds a line, transmit-ready is set and the line number is placed in status bits 9:8. If transmit-interrupt enable (status bit 5) is set, `irq` goes high.
- R4: If a scan sets transmit-ready, receive-done is left clear in that scan and no receive interrupt is raised.
- R5: Every scan first clears receive-done (status bit 12). Unless R4 applies, it then sets receive-done when `rx_avail` is high and scan-enable is set, and raises `irq` if receive-interrupt enable (status bit 4) is set. This also happens when transmit-ready was already set before the scan.
- R6: A status write (offset 0x00) changes only bits 0 (scan enable), 1 (clear), 2 (loopback), 4 and 5. Writing scan-enable as 0 also clears transmit-ready and receive-done. Bits 1 and 2 drive `clr_req` and `loop_mode`.
- R7: A transmit-control write (offset 0x10) loads the register, clears transmit-ready and drops `irq`. A read returns the stored value.
- R8: A transmit-data write (offset 0x18) pulses `tx_valid` for one cycle after the write, carrying the low 8 data bits on `tx_byte` and status bits 9:8 on `tx_line`. It clears transmit-ready and drops `irq`.
- R9: The clear bit reads back as 0, and any register access resets it.
- R10: After reset the status word reads 0x2001 (scan enable and transmit-ready set, line 0), transmit control reads 0, and `irq` is low.
- R11: A read of offset 0x18 returns `modem_in` with bits 2, 3, 10 and 11 forced to 1. These are the data-set-ready (bits 2, 3) and carrier-detect (bits 10, 11) flags of lines 2 and 3.
- R12: A read of offset 0x08 returns bit 15 = 1, bits 9:8 = `rx_line`, bits 7:0 = `rx_char` when `rx_avail` is high, and returns 0 otherwise. When `rx_avail` is high it pulses `rx_pop`. It clears receive-done and drops `irq`. A write to 0x08 loads `line_cfg`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_tick | input | 1 | One-cycle scan strobe |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the access cycle |
| rx_avail | input | 1 | Receive queue holds a character |
| rx_char | input | 8 | Character at the queue head |
| rx_line | input | 2 | Line number at the queue head |
| rx_pop | output | 1 | Remove the queue head |
| modem_in | input | 16 | Raw modem status |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_line | output | 2 | Line for the transmit byte |
| tx_byte | output | 8 | Transmit byte |
| line_cfg | output | 16 | Line-configuration word |
| clr_req | output | 1 | Clear request bit from the status word |
| loop_mode | output | 1 | Loopback bit from the status word |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is R4. It needs transmit-ready clear, a transmit-enabled line waiting and receive data pending, all at the moment the same scan runs. The stimulus holds `rx_avail` high and writes a transmit byte, so the follow-up scan re-finds a line. It then checks that receive-done and `irq` stay low until the next scan, where the receive path alone raises them. The wrap of the rotating pointer past line 3 is driven by enabling only some lines and sending bytes in turn, each through the scoreboard of expected line/byte pairs.

// File: rtl/muxsio_pkg.sv
package muxsio_pkg;

    // status word bit positions
    localparam int ST_SCAN_EN  = 0;
    localparam int ST_CLEAR    = 1;
    localparam int ST_LOOP     = 2;
    localparam int ST_RX_IE    = 4;
    localparam int ST_TX_IE    = 5;
    localparam int ST_LINE_LSB = 8;
    localparam int ST_RX_DONE  = 12;
    localparam int ST_TX_RDY   = 13;

    // receive buffer word
    localparam int RB_VALID    = 15;
    localparam int RB_LINE_LSB = 8;

    // modem status bits forced high on read
    localparam logic [15:0] MODEM_FORCE = 16'h0C0C;

    // register offsets
    localparam int OFS_CSR = 'h00;
    localparam int OFS_BUF = 'h08;
    localparam int OFS_TCR = 'h10;
    localparam int OFS_TDR = 'h18;

    typedef enum logic [2:0] {
        RD_NONE,
        RD_CSR,
        RD_BUF,
        RD_TCR,
        RD_MODEM
    } rd_sel_e;

    typedef struct packed {
        logic    any;
        logic    csr_wr;
        logic    cfg_wr;
        logic    tcr_wr;
        logic    tdr_wr;
        logic    buf_rd;
        rd_sel_e rsel;
    } acc_t;

endpackage

// File: rtl/muxsio_bus_dec.sv
module muxsio_bus_dec
    import muxsio_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output acc_t              acc
);
    logic hit_csr, hit_buf, hit_tcr, hit_tdr;

    always_comb begin
        hit_csr = (addr == ADDR_W'(OFS_CSR));
        hit_buf = (addr == ADDR_W'(OFS_BUF));
        hit_tcr = (addr == ADDR_W'(OFS_TCR));
        hit_tdr = (addr == ADDR_W'(OFS_TDR));

        acc        = '0;
        acc.rsel   = RD_NONE;
        acc.any    = sel;
        acc.csr_wr = sel &  we & hit_csr;
        acc.cfg_wr = sel &  we & hit_buf;
        acc.tcr_wr = sel &  we & hit_tcr;
        acc.tdr_wr = sel &  we & hit_tdr;
        acc.buf_rd = sel & ~we & hit_buf;
        if (sel && !we) begin
            if (hit_csr)      acc.rsel = RD_CSR;
            else if (hit_buf) acc.rsel = RD_BUF;
            else if (hit_tcr) acc.rsel = RD_TCR;
            else if (hit_tdr) acc.rsel = RD_MODEM;
        end
    end
endmodule

// File: rtl/muxsio_rr_pick.sv
module muxsio_rr_pick #(
    parameter int LINES = 4,
    parameter int LW    = $clog2(LINES)
) (
    input  logic [LW-1:0]    ptr,
    input  logic [LINES-1:0] en,
    output logic             found,
    output logic [LW-1:0]    idx
);
    logic [LW-1:0]    cand [LINES];
    logic [LINES-1:0] hit;

    // candidate k is the line k+1 steps after the pointer, wrapped
    for (genvar k = 0; k < LINES; k++) begin : g_cand
        logic [LW:0] sum;
        assign sum     = {1'b0, ptr} + (LW+1)'(k + 1);
        assign cand[k] = (sum >= (LW+1)'(LINES)) ? LW'(sum - (LW+1)'(LINES))
                                                  : sum[LW-1:0];
        assign hit[k]  = en[cand[k]];
    end

    always_comb begin
        found = 1'b0;
        idx   = ptr;
        for (int j = LINES - 1; j >= 0; j--) begin
            if (hit[j]) begin
                found = 1'b1;
                idx   = cand[j];
            end
        end
    end
endmodule

// File: rtl/muxsio_rd_mux.sv
module muxsio_rd_mux
    import muxsio_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  rd_sel_e          rsel,
    input  logic [REG_W-1:0] csr_view,
    input  logic [REG_W-1:0] tcr,
    input  logic [REG_W-1:0] buf_word,
    input  logic [REG_W-1:0] modem_in,
    output logic [REG_W-1:0] rdata
);
    always_comb begin
        unique case (rsel)
            RD_CSR:   rdata = csr_view;
            RD_BUF:   rdata = buf_word;
            RD_TCR:   rdata = tcr;
            RD_MODEM: rdata = modem_in | REG_W'(MODEM_FORCE);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/muxsio_ctl.sv
module muxsio_ctl
    import muxsio_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int REG_W  = 16,
    parameter int CHAR_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_tick,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              rx_avail,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic [$clog2(LINES)-1:0] rx_line,
    output logic              rx_pop,
    input  logic [REG_W-1:0]  modem_in,
    output logic              tx_valid,
    output logic [$clog2(LINES)-1:0] tx_line,
    output logic [CHAR_W-1:0] tx_byte,
    output logic [REG_W-1:0]  line_cfg,
    output logic              clr_req,
    output logic              loop_mode,
    output logic              irq
);
    localparam int LW = $clog2(LINES);

    typedef struct packed {
        logic              tx_rdy;
        logic              rx_done;
        logic              scan_en;
        logic              tx_ie;
        logic              rx_ie;
        logic              clr;
        logic              loop;
        logic [LW-1:0]     line;
        logic [LW-1:0]     ptr;
        logic [REG_W-1:0]  tcr;
        logic [REG_W-1:0]  cfg;
        logic              irq;
        logic              pend;
        logic              txv;
        logic [LW-1:0]     txl;
        logic [CHAR_W-1:0] txb;
    } state_t;

    state_t s_d, s_q;
    acc_t   acc;
    logic   pick_found;
    logic [LW-1:0] pick_idx;
    logic   run_scan;
    logic [REG_W-1:0] csr_view, buf_word;

    muxsio_bus_dec #(.ADDR_W(ADDR_W)) u_dec (
        .sel  (bus_sel),
        .we   (bus_we),
        .addr (bus_addr),
        .acc  (acc)
    );

    muxsio_rr_pick #(.LINES(LINES), .LW(LW)) u_pick (
        .ptr   (s_q.ptr),
        .en    (s_q.tcr[LINES-1:0]),
        .found (pick_found),
        .idx   (pick_idx)
    );

    // status view; the clear bit is always seen as zero by a read
    always_comb begin
        csr_view = '0;
        csr_view[ST_SCAN_EN] = s_q.scan_en;
        csr_view[ST_LOOP]    = s_q.loop;
        csr_view[ST_RX_IE]   = s_q.rx_ie;
        csr_view[ST_TX_IE]   = s_q.tx_ie;
        csr_view[ST_LINE_LSB +: LW] = s_q.line;
        csr_view[ST_RX_DONE] = s_q.rx_done;
        csr_view[ST_TX_RDY]  = s_q.tx_rdy;

        buf_word = '0;
        if (rx_avail) begin
            buf_word[RB_VALID]          = 1'b1;
            buf_word[RB_LINE_LSB +: LW] = rx_line;
            buf_word[CHAR_W-1:0]        = rx_char;
        end
    end

    muxsio_rd_mux #(.REG_W(REG_W)) u_rd (
        .rsel     (acc.rsel),
        .csr_view (csr_view),
        .tcr      (s_q.tcr),
        .buf_word (buf_word),
        .modem_in (modem_in),
        .rdata    (bus_rdata)
    );

    assign run_scan = (scan_tick | s_q.pend) & ~acc.any;

    always_comb begin
        logic tx_found;
        s_d      = s_q;
        s_d.txv  = 1'b0;
        s_d.pend = acc.any;
        tx_found = 1'b0;

        if (acc.any) begin
            s_d.clr = 1'b0;
            if (acc.csr_wr) begin
                s_d.scan_en = bus_wdata[ST_SCAN_EN];
                s_d.clr     = bus_wdata[ST_CLEAR];
                s_d.loop    = bus_wdata[ST_LOOP];
                s_d.rx_ie   = bus_wdata[ST_RX_IE];
                s_d.tx_ie   = bus_wdata[ST_TX_IE];
                if (!bus_wdata[ST_SCAN_EN]) begin
                    s_d.tx_rdy  = 1'b0;
                    s_d.rx_done = 1'b0;
                end
            end
            if (acc.cfg_wr) begin
                s_d.cfg = bus_wdata;
            end
            if (acc.tcr_wr) begin
                s_d.tcr    = bus_wdata;
                s_d.tx_rdy = 1'b0;
                s_d.irq    = 1'b0;
            end
            if (acc.tdr_wr) begin
                s_d.txv    = 1'b1;
                s_d.txb    = bus_wdata[CHAR_W-1:0];
                s_d.txl    = s_q.line;
                s_d.tx_rdy = 1'b0;
                s_d.irq    = 1'b0;
            end
            if (acc.buf_rd) begin
                s_d.rx_done = 1'b0;
                s_d.irq     = 1'b0;
            end
        end else if (run_scan) begin
            s_d.rx_done = 1'b0;
            if (s_q.scan_en && !s_q.tx_rdy && pick_found) begin
                s_d.tx_rdy = 1'b1;
                s_d.line   = pick_idx;
                s_d.ptr    = pick_idx;
                tx_found   = 1'b1;
                if (s_q.tx_ie) s_d.irq = 1'b1;
            end
            if (!tx_found && rx_avail && s_q.scan_en) begin
                s_d.rx_done = 1'b1;
                if (s_q.rx_ie) s_d.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.tx_rdy  <= 1'b1;
            s_q.scan_en <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign rx_pop    = acc.buf_rd & rx_avail;
    assign tx_valid  = s_q.txv;
    assign tx_line   = s_q.txl;
    assign tx_byte   = s_q.txb;
    assign line_cfg  = s_q.cfg;
    assign clr_req   = s_q.clr;
    assign loop_mode = s_q.loop;
    assign irq       = s_q.irq;

    AST_RDY_FROM_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.tx_rdy) |-> $past(run_scan && s_q.scan_en)); // R1
    AST_RDY_LINE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.tx_rdy) |-> s_q.tcr[s_q.line]); // R2
    AST_RX_SUPPRESSED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.tx_rdy) |-> !s_q.rx_done); // R4
    AST_SCAN_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.scan_en |-> (!s_q.tx_rdy && !s_q.rx_done)); // R6
    AST_TCR_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc.tcr_wr) |-> (!irq && !s_q.tx_rdy)); // R7
    AST_TX_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (!irq && !s_q.tx_rdy)); // R8
    AST_POP_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> (bus_sel && !bus_we && rx_avail)); // R12

endmodule

// File: tb/sim_muxsio_ctl.sv
`timescale 1ns/1ps
module sim_muxsio_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_tick = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rx_avail = 1'b0;
    logic [7:0]  rx_char = '0;
    logic [1:0]  rx_line = '0;
    logic        rx_pop;
    logic [15:0] modem_in = '0;
    logic        tx_valid;
    logic [1:0]  tx_line;
    logic [7:0]  tx_byte;
    logic [15:0] line_cfg;
    logic        clr_req, loop_mode, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [9:0] exp_q[$];

    always #4 clk = ~clk;

    muxsio_ctl u0 (
        .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_avail(rx_avail), .rx_char(rx_char), .rx_line(rx_line),
        .rx_pop(rx_pop), .modem_in(modem_in),
        .tx_valid(tx_valid), .tx_line(tx_line), .tx_byte(tx_byte),
        .line_cfg(line_cfg), .clr_req(clr_req), .loop_mode(loop_mode),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [15:0] d, output logic pop);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata; pop = rx_pop;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // driver side: expected transmit pairs
    task automatic send(input logic [1:0] ln, input logic [15:0] d);
        exp_q.push_back({ln, d[7:0]});
        bus_write(5'h18, d);
    endtask

    // monitor side
    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            if (exp_q.size() == 0) begin
                chk("R8 unexpected tx", {6'd0, tx_line, tx_byte}, 16'h0);
            end else begin
                logic [9:0] e;
                e = exp_q.pop_front();
                chk("R8 tx line/byte", {6'd0, tx_line, tx_byte}, {6'd0, e});
            end
        end
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        logic        pop;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        chk("R10 irq", {15'd0, irq}, 16'h0);
        bus_read(5'h00, rd, pop); chk("R10 status", rd, 16'h2001);
        bus_read(5'h10, rd, pop); chk("R10 tcr", rd, 16'h0000);

        // enable lines 1 and 2
        bus_write(5'h10, 16'h0006);
        bus_read(5'h10, rd, pop); chk("R7 tcr readback", rd, 16'h0006);
        bus_read(5'h00, rd, pop); chk("R2 first ready line 1", rd, 16'h2101);
        chk("R3 no irq without enable", {15'd0, irq}, 16'h0);

        send(2'd1, 16'h01A5);
        bus_read(5'h00, rd, pop); chk("R2 next line 2", rd, 16'h2201);
        send(2'd2, 16'h003C);
        bus_read(5'h00, rd, pop); chk("R2 wrap to line 1", rd, 16'h2101);

        // transmit interrupt enable
        bus_write(5'h00, 16'h0021);
        chk("R6 csr write keeps ready", {15'd0, irq}, 16'h0);
        send(2'd1, 16'h0077);
        @(negedge clk);
        chk("R3 tx irq", {15'd0, irq}, 16'h1);
        bus_read(5'h00, rd, pop); chk("R3 line 2 ready", rd, 16'h2221);

        bus_write(5'h10, 16'h0000);
        chk("R7 irq ack", {15'd0, irq}, 16'h0);
        repeat (3) begin
            @(negedge clk); scan_tick = 1'b1;
            @(negedge clk); scan_tick = 1'b0;
        end
        bus_read(5'h00, rd, pop); chk("R2 no enabled line", rd, 16'h0221);

        bus_write(5'h10, 16'h0008);
        bus_read(5'h00, rd, pop); chk("R2 only line 3", rd, 16'h2321);

        // receive path with transmit-ready already set
        rx_avail = 1'b1; rx_char = 8'h5A; rx_line = 2'd2;
        bus_write(5'h00, 16'h0011);
        bus_read(5'h00, rd, pop); chk("R5 rx done", rd, 16'h3311);
        chk("R5 rx irq", {15'd0, irq}, 16'h1);
        bus_read(5'h08, rd, pop); chk("R12 buffer word", rd, 16'h825A);
        chk("R12 pop", {15'd0, pop}, 16'h1);
        rx_avail = 1'b0;
        chk("R12 irq ack", {15'd0, irq}, 16'h0);
        bus_read(5'h00, rd, pop); chk("R12 rx done cleared", rd, 16'h2311);

        // R4: the scan that finds a line keeps receive-done clear
        rx_avail = 1'b1;
        send(2'd3, 16'h0042);
        @(negedge clk);
        chk("R4 no irq", {15'd0, irq}, 16'h0);
        bus_read(5'h00, rd, pop); chk("R4 rx done suppressed", rd, 16'h2311);
        @(negedge clk);
        chk("R5 irq next scan", {15'd0, irq}, 16'h1);
        bus_read(5'h00, rd, pop); chk("R5 rx done next scan", rd, 16'h3311);

        // R1: scan only on tick when no access is pending
        rx_avail = 1'b0;
        bus_read(5'h08, rd, pop); chk("R12 empty buffer", rd, 16'h0000);
        chk("R12 no pop when empty", {15'd0, pop}, 16'h0);
        repeat (2) @(negedge clk);
        rx_avail = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 no scan without tick", {15'd0, irq}, 16'h0);
        scan_tick = 1'b1;
        @(negedge clk);
        scan_tick = 1'b0;
        chk("R1 tick scan", {15'd0, irq}, 16'h1);
        rx_avail = 1'b0;

        // writable bits and clear bit
        bus_write(5'h00, 16'hFFFF);
        chk("R6 clr_req", {15'd0, clr_req}, 16'h1);
        chk("R6 loop_mode", {15'd0, loop_mode}, 16'h1);
        bus_read(5'h00, rd, pop); chk("R9 clear reads zero", rd, 16'h2335);
        chk("R9 clear reset by access", {15'd0, clr_req}, 16'h0);

        bus_write(5'h08, 16'h1234);
        chk("R12 line_cfg", line_cfg, 16'h1234);

        modem_in = 16'h0101;
        bus_read(5'h18, rd, pop); chk("R11 modem forced", rd, 16'h0D0D);
        modem_in = 16'h0000;
        bus_read(5'h18, rd, pop); chk("R11 modem bare", rd, 16'h0C0C);

        // scan enable off
        bus_write(5'h00, 16'h0000);
        bus_write(5'h10, 16'h000F);
        @(negedge clk); scan_tick = 1'b1;
        @(negedge clk); scan_tick = 1'b0;
        bus_read(5'h00, rd, pop); chk("R6 scan off clears ready", rd, 16'h0300);
        bus_write(5'h00, 16'h0001);
        bus_read(5'h00, rd, pop); chk("R1 scan resumes at line 0", rd, 16'h2001);

        repeat (3) @(negedge clk);
        chk("R8 all tx seen", 16'(exp_q.size()), 16'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule